// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block keeps the three status bits of a software-sequenced non-restoring divide: the quotient-sign bit Q, the divisor-sign bit M and the result bit T. It also evaluates one division step per command. Software starts a divide with one of two initialise commands. The unsigned form zeroes the status bits. The signed form derives the status bits from the sign bits of a dividend and a divisor.

After initialising, software issues repeated step commands. Each step command supplies a partial remainder and a divisor. The block returns the new partial remainder and updates Q and T; M is not changed by a step. A step shifts the remainder left, takes T into bit 0, and then adds or subtracts the divisor according to Q and M.

Software builds the quotient by rotating bits through T. For that reason the block also accepts a command that writes T directly. Every command completes in one clock cycle, and the ready output is always high.

Top module: `div_step_unit`

## Requirements
- R1: While reset is asserted, and on its release, q_o, m_o and t_o are 0 and rem_o is 0. ready_o is 1 at all times.
- R2: An unsigned initialise command (init_u_i) sets q_o, m_o and t_o to 0 on the next clock edge.
- R3: A signed initialise command (init_s_i) loads q_o with dividend_i bit WIDTH-1 and m_o with divisor_i bit WIDTH-1. It loads t_o with the XOR of those two bits.
- R4: When several strobes are high together, only one command runs, in this priority: init_u_i, then init_s_i, then t_wr_i, then step_i.
- R5: A step with q_o equal to m_o subtracts divisor_i from the shifted remainder. Its carry term is 1 exactly when the subtraction borrows.
- R6: A step with q_o different from m_o adds divisor_i to the shifted remainder. Its carry term is 1 exactly when the addition wraps past 2^WIDTH.
- R7: A step forms the shifted remainder as rem_i shifted left by one, with the old t_o placed in bit 0. The add or subtract result appears on rem_o after the clock edge.
- R8: After a step, q_o equals rem_i bit WIDTH-1 XOR m_o XOR the carry term, and t_o is 1 exactly when the new q_o equals m_o.
- R9: A step leaves m_o unchanged. A cycle with no strobe leaves q_o, m_o, t_o and rem_o unchanged.
- R10: A T-write command (t_wr_i) loads t_o from t_val_i and leaves q_o, m_o and rem_o unchanged.
- R11: With rotate-through-T done outside the block, a 16-step or 32-step sequence yields the unsigned quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_u_i | input | 1 | Unsigned initialise strobe |
| init_s_i | input | 1 | Signed initialise strobe |
| t_wr_i | input | 1 | T write strobe |
| t_val_i | input | 1 | Value written to T |
| step_i | input | 1 | Division step strobe |
| dividend_i | input | WIDTH | Dividend, used by signed initialise |
| divisor_i | input | WIDTH | Divisor, used by signed initialise and by step |
| rem_i | input | WIDTH | Partial remainder entering a step |
| rem_o | output | WIDTH | Partial remainder after the last step |
| q_o | output | 1 | Q status bit |
| m_o | output | 1 | M status bit |
| t_o | output | 1 | T status bit |
| ready_o | output | 1 | Command acceptance, always 1 |

## Verification
Single steps are driven from each of the four Q/M combinations. The subtract path is tried both with and without a borrow, and the add path both with and without a wrap, so that a swapped direction or an inverted carry shows up in rem_o or q_o. A set T is inserted into the shifted remainder, which tells apart a design that inserts old T from one that inserts zero. Complete 16-step and 32-step unsigned divides, compared against integer division, catch errors that build up over many steps. Strobes raised together check the command priority.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_INIT_U,
    CMD_INIT_S,
    CMD_T_WR,
    CMD_STEP
  } cmd_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } status_t;
endpackage

// File: rtl/div_step_decode.sv
module div_step_decode
  import div_step_pkg::*;
(
  input  logic init_u_i,
  input  logic init_s_i,
  input  logic t_wr_i,
  input  logic step_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (init_u_i)      cmd_o = CMD_INIT_U;
    else if (init_s_i) cmd_o = CMD_INIT_S;
    else if (t_wr_i)   cmd_o = CMD_T_WR;
    else if (step_i)   cmd_o = CMD_STEP;
    else               cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/div_step_alu.sv
module div_step_alu
  import div_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  status_t          st_i,
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] div_i,
  output logic [WIDTH-1:0] rem_o,
  output status_t          st_o
);
  logic             dir;
  logic             msb;
  logic             carry;
  logic             nq;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] diff;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    dir      = st_i.q ^ st_i.m;
    msb      = rem_i[WIDTH-1];
    shifted  = {rem_i[WIDTH-2:0], st_i.t};
    sum      = shifted + div_i;
    diff     = shifted - div_i;
    // carry/borrow read back from the wrapped result
    carry    = dir ? (sum < shifted) : (diff > shifted);
    rem_o    = dir ? sum : diff;
    nq       = msb ^ st_i.m ^ carry;
    st_o.q   = nq;
    st_o.m   = st_i.m;
    st_o.t   = (nq == st_i.m);
  end

  assign wide_sum = {1'b0, shifted} + {1'b0, div_i};

  always_comb begin
    p_borrow_r5: assert (dir || (carry == (div_i > shifted)))
      else $error("subtract carry term disagrees with borrow");
    p_wrap_r6: assert (!dir || (carry == wide_sum[WIDTH]))
      else $error("add carry term disagrees with wrap");
  end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_u_i,
  input  logic             init_s_i,
  input  logic             t_wr_i,
  input  logic             t_val_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  input  logic [WIDTH-1:0] rem_i,
  output logic [WIDTH-1:0] rem_o,
  output logic             q_o,
  output logic             m_o,
  output logic             t_o,
  output logic             ready_o
);
  localparam int MSB = WIDTH - 1;

  cmd_e             cmd;
  status_t          st_q;
  status_t          st_nxt;
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] rem_nxt;

  div_step_decode u_dec (
    .init_u_i (init_u_i),
    .init_s_i (init_s_i),
    .t_wr_i   (t_wr_i),
    .step_i   (step_i),
    .cmd_o    (cmd)
  );

  div_step_alu #(.WIDTH(WIDTH)) u_alu (
    .st_i  (st_q),
    .rem_i (rem_i),
    .div_i (divisor_i),
    .rem_o (rem_nxt),
    .st_o  (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      rem_q <= '0;
    end else begin
      unique case (cmd)
        CMD_INIT_U: st_q <= '0;
        CMD_INIT_S: begin
          st_q.q <= dividend_i[MSB];
          st_q.m <= divisor_i[MSB];
          st_q.t <= dividend_i[MSB] ^ divisor_i[MSB];
        end
        CMD_T_WR: st_q.t <= t_val_i;
        CMD_STEP: begin
          st_q  <= st_nxt;
          rem_q <= rem_nxt;
        end
        default: ;
      endcase
    end
  end

  assign rem_o   = rem_q;
  assign q_o     = st_q.q;
  assign m_o     = st_q.m;
  assign t_o     = st_q.t;
  assign ready_o = 1'b1;

  p_uinit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_u_i |=> (!q_o && !m_o && !t_o));

  p_sinit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_s_i && !init_u_i) |=>
      (q_o == $past(dividend_i[MSB]) && m_o == $past(divisor_i[MSB])
       && t_o == (q_o ^ m_o)));

  p_step_t_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_u_i && !init_s_i && !t_wr_i) |=> (t_o == (q_o == m_o)));

  p_step_m_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_u_i && !init_s_i && !t_wr_i) |=> $stable(m_o));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_u_i && !init_s_i && !t_wr_i && !step_i) |=>
      ($stable(q_o) && $stable(m_o) && $stable(t_o) && $stable(rem_o)));

  p_twr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_wr_i && !init_u_i && !init_s_i) |=>
      (t_o == $past(t_val_i) && $stable(q_o) && $stable(m_o) && $stable(rem_o)));
endmodule

// File: tb/div_step_unit_test.sv
module div_step_unit_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         init_u_i = 1'b0, init_s_i = 1'b0, t_wr_i = 1'b0, t_val_i = 1'b0, step_i = 1'b0;
  logic [W-1:0] dividend_i = '0, divisor_i = '0, rem_i = '0;
  logic [W-1:0] rem_o;
  logic         q_o, m_o, t_o, ready_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  div_step_unit #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .init_u_i(init_u_i), .init_s_i(init_s_i),
    .t_wr_i(t_wr_i), .t_val_i(t_val_i), .step_i(step_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .rem_i(rem_i),
    .rem_o(rem_o), .q_o(q_o), .m_o(m_o), .t_o(t_o), .ready_o(ready_o)
  );

  // vector table: init kind (1=signed), init operands, step operands, expected results
  localparam int NV = 5;
  localparam logic         V_SGN [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [W-1:0] V_DVD [NV] = '{32'h0, 32'h0, 32'h8000_0000, 32'h0000_0005, 32'hFFFF_FFF0};
  localparam logic [W-1:0] V_DVI [NV] = '{32'h0, 32'h0, 32'h0000_0003, 32'hFFFF_FFFE, 32'hFFFF_FFFD};
  localparam logic [W-1:0] V_REM [NV] = '{32'h0000_0010, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 32'hC000_0000};
  localparam logic [W-1:0] V_DIV [NV] = '{32'h0000_0003, 32'h0000_0005, 32'h0000_0003, 32'hFFFF_FFFE, 32'hFFFF_FFFD};
  localparam logic [W-1:0] E_REM [NV] = '{32'h0000_001D, 32'hFFFF_FFFD, 32'h0000_0004, 32'hFFFF_FFFD, 32'h8000_0003};
  localparam logic [2:0]   E_QMT [NV] = '{3'b001, 3'b100, 3'b100, 3'b010, 3'b111};

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    init_u_i = 0; init_s_i = 0; t_wr_i = 0; step_i = 0;
  endtask

  task automatic cmd_init_u();
    @(negedge clk); idle(); init_u_i = 1;
    @(negedge clk); idle();
  endtask

  task automatic cmd_init_s(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk); idle(); init_s_i = 1; dividend_i = a; divisor_i = b;
    @(negedge clk); idle();
  endtask

  task automatic cmd_t(input logic v);
    @(negedge clk); idle(); t_wr_i = 1; t_val_i = v;
    @(negedge clk); idle();
  endtask

  task automatic cmd_step(input logic [W-1:0] r, input logic [W-1:0] d);
    @(negedge clk); idle(); step_i = 1; rem_i = r; divisor_i = d;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, lo;
    logic         ot;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk("R1 reset qmt", {29'd0, q_o, m_o, t_o}, '0);
    chk("R1 reset rem", rem_o, '0);
    chk("R1 ready", {31'd0, ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, q_o, m_o, t_o}, '0);

    // table: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      if (V_SGN[i]) cmd_init_s(V_DVD[i], V_DVI[i]);
      else          cmd_init_u();
      if (V_SGN[i]) begin
        chk("R3 init q", {31'd0, q_o}, {31'd0, V_DVD[i][W-1]});
        chk("R3 init m", {31'd0, m_o}, {31'd0, V_DVI[i][W-1]});
        chk("R3 init t", {31'd0, t_o}, {31'd0, V_DVD[i][W-1] ^ V_DVI[i][W-1]});
      end else begin
        chk("R2 init clears", {29'd0, q_o, m_o, t_o}, '0);
      end
      cmd_step(V_REM[i], V_DIV[i]);
      chk("R7 step rem", rem_o, E_REM[i]);
      chk("R8 step qmt", {29'd0, q_o, m_o, t_o}, {29'd0, E_QMT[i]});
    end

    // R9: idle cycles hold everything
    r = rem_o;
    @(negedge clk); @(negedge clk);
    chk("R9 idle rem", rem_o, r);
    chk("R9 idle qmt", {29'd0, q_o, m_o, t_o}, {29'd0, E_QMT[NV-1]});

    // R10: T write, then R7 old-T insertion with subtract no borrow
    cmd_init_u();
    cmd_t(1'b1);
    chk("R10 t loaded", {29'd0, q_o, m_o, t_o}, 32'd1);
    chk("R10 rem held", rem_o, r);
    cmd_step(32'h0000_0004, 32'h0000_0002);  // shifted 9, minus 2 = 7
    chk("R7 old T into bit0", rem_o, 32'h0000_0007);

    // R4: priority
    @(negedge clk); idle(); init_u_i = 1; init_s_i = 1; dividend_i = '1; divisor_i = '1;
    @(negedge clk); idle();
    chk("R4 init_u over init_s", {29'd0, q_o, m_o, t_o}, '0);
    @(negedge clk); idle(); init_s_i = 1; t_wr_i = 1; t_val_i = 0; step_i = 1;
    dividend_i = 32'h8000_0000; divisor_i = 32'h0; rem_i = 32'h1;
    @(negedge clk); idle();
    chk("R4 init_s over t_wr/step", {29'd0, q_o, m_o, t_o}, 32'b101);
    chk("R4 step suppressed", rem_o, 32'h0000_0007);
    @(negedge clk); idle(); t_wr_i = 1; t_val_i = 0; step_i = 1; rem_i = 32'h1; divisor_i = 32'h1;
    @(negedge clk); idle();
    chk("R4 t_wr over step", {29'd0, q_o, m_o, t_o}, 32'b100);
    chk("R4 step suppressed rem", rem_o, 32'h0000_0007);

    // R11: 16-step divides, divisor in upper half
    for (int k = 0; k < 4; k++) begin
      logic [15:0] dv;
      logic [W-1:0] dd;
      dv = 16'(3 + k * 1237);
      dd = {16'(dv - 1), 16'(16'hA5C3 + k * 911)} % {dv, 16'h0};
      cmd_init_u();
      r = dd;
      for (int s = 0; s < 16; s++) begin
        cmd_step(r, {dv, 16'h0});
        r = rem_o;
      end
      lo = {r[W-2:0], t_o};
      chk("R11 16-step quotient", {16'd0, lo[15:0]}, {16'd0, 16'(dd / {16'd0, dv})});
    end

    // R11: 32-step divides with external rotate-through-T
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] dv, dd;
      dd = 32'hDEAD_BEEF - k * 32'h1357_9BDF;
      dv = 32'd7 + k * 32'h0012_3457;
      cmd_init_u();
      r = '0; lo = dd;
      for (int s = 0; s < 32; s++) begin
        ot = t_o;
        cmd_t(lo[W-1]);
        lo = {lo[W-2:0], ot};
        cmd_step(r, dv);
        r = rem_o;
      end
      lo = {lo[W-2:0], t_o};
      chk("R11 32-step quotient", lo, dd / dv);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule